// File: doc/BRIEF.md
# CPU Interrupt versus Transfer Request Priority Arbiter

This block decides which of two pending requests is served first: an interrupt exception for the processor, or a request from the data-transfer controller. A single 8-bit configuration register sets the rules. It holds a master enable bit, a 3-bit priority level for the transfer engine, a tracking enable bit and a 3-bit priority level for the processor. A simple write port loads the register, and the register's contents always appear on a read port.

When the master enable bit is clear, the processor is treated as the lowest priority. Any pending transfer request then wins. When the master enable bit is set, the two 3-bit levels are compared. The processor wins only when its level is strictly higher; on equal levels the transfer wins. When the tracking bit is set, the processor level is copied from the processor's current interrupt mask level on every clock, and bus writes to that field are dropped.

Top module: `cpu_xfer_arbiter`

## Requirements
- R1: While reset is active and directly after it, the register reads 0x00, and no grant is asserted unless a request is present.
- R2: Register bit 7 is the master enable, bits [6:4] are the transfer level (0 lowest, 7 highest), bit 3 is the tracking enable and bits [2:0] are the processor level. When the stored tracking bit is 0, a write stores all 8 bits, and they appear on `rdData` after that clock edge.
- R3: While the stored tracking bit is 1, each rising edge loads the processor level from `maskLvl`, and the new value appears on `rdData` after that edge.
- R4: While the stored tracking bit is 1, a write updates bits [7:3] but not bits [2:0]. This also holds for a write that clears the tracking bit.
- R5: While the stored tracking bit is 0 and no write occurs, the processor level holds its value whatever `maskLvl` does.
- R6: With master enable 0 and both requests pending, `xferGnt` is asserted, whatever the two levels are.
- R7: With master enable 1 and both requests pending, `cpuGnt` is asserted when the processor level is strictly greater than the transfer level. Otherwise `xferGnt` is asserted, including when the levels are equal.
- R8: A sole requester is always granted. No request gives no grant. At most one grant is high at any time.
- R9: Grants are combinational from the stored register and the current request inputs, so they follow a change of request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write value |
| rdData | output | 8 | Current register contents |
| maskLvl | input | 3 | Processor interrupt mask level |
| cpuReq | input | 1 | Pending processor interrupt exception |
| xferReq | input | 1 | Pending transfer request |
| cpuGnt | output | 1 | Grant to the processor interrupt |
| xferGnt | output | 1 | Grant to the transfer engine |

## Verification
Two functions can act in the same cycle: the automatic load of the processor level from the mask input, and a bus write. The bench drives a write while tracking is on, with `maskLvl` and the processor bits of `wrData` set to different values. It then checks that the upper bits take the written value while the low field takes the mask value. It also writes a value that clears the tracking bit while tracking is on, and checks that the clearing write still drops its processor bits. A long pseudo-random run keeps writes, mask changes and requests overlapping in the same cycle. Every result is compared with the scoreboard's expected value.

// File: rtl/cpu_xfer_arbiter_pkg.sv
package cpu_xfer_arbiter_pkg;

  parameter int LVL_W = 3;
  localparam int REG_W = 2 * LVL_W + 2;

  // Bit positions of the configuration word
  localparam int CPU_LSB   = 0;
  localparam int TRACK_BIT = LVL_W;
  localparam int XFER_LSB  = LVL_W + 1;
  localparam int EN_BIT    = 2 * LVL_W + 1;

  typedef struct packed {
    logic             ctlEn;
    logic [LVL_W-1:0] xferLvl;
    logic             trackEn;
    logic [LVL_W-1:0] cpuLvl;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadUpper;
    logic cpuFromBus;
    logic cpuFromMask;
  } strobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import cpu_xfer_arbiter_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    trackEn,
  output strobe_t strobe
);

  always_comb begin
    strobe             = '0;
    strobe.loadUpper   = wrEn;
    strobe.cpuFromMask = trackEn;
    strobe.cpuFromBus  = wrEn && !trackEn;
  end

  AST_SINGLE_CPU_SRC: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cpuFromBus && strobe.cpuFromMask)) else $error("cpu level has two sources"); // R4

endmodule

// File: rtl/arb_regs.sv
module arb_regs
  import cpu_xfer_arbiter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic [LVL_W-1:0] maskLvl,
  output cfg_t             cfgQ
);

  cfg_t cfgD;

  always_comb begin
    cfgD = cfgQ;
    if (strobe.loadUpper) begin
      cfgD.ctlEn   = wrData[EN_BIT];
      cfgD.xferLvl = wrData[XFER_LSB +: LVL_W];
      cfgD.trackEn = wrData[TRACK_BIT];
    end
    if (strobe.cpuFromMask)
      cfgD.cpuLvl = maskLvl;
    else if (strobe.cpuFromBus)
      cfgD.cpuLvl = wrData[CPU_LSB +: LVL_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgD;
  end

  AST_TRACK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.trackEn |=> cfgQ.cpuLvl == $past(maskLvl)) else $error("tracking load missed"); // R3

  AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ.trackEn && !strobe.loadUpper) |=> $stable(cfgQ.cpuLvl)) else $error("cpu level drifted"); // R5

  AST_UPPER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadUpper |=> {cfgQ.ctlEn, cfgQ.xferLvl, cfgQ.trackEn} == $past(wrData[REG_W-1:TRACK_BIT]))
    else $error("upper bits not written"); // R2

endmodule

// File: rtl/arb_grant.sv
module arb_grant
  import cpu_xfer_arbiter_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  cfg_t cfgQ,
  input  logic cpuReq,
  input  logic xferReq,
  output logic cpuGnt,
  output logic xferGnt
);

  logic cpuAhead;

  assign cpuAhead = cfgQ.ctlEn && (cfgQ.cpuLvl > cfgQ.xferLvl);

  always_comb begin
    cpuGnt  = 1'b0;
    xferGnt = 1'b0;
    unique case ({cpuReq, xferReq})
      2'b10:   cpuGnt  = 1'b1;
      2'b01:   xferGnt = 1'b1;
      2'b11: begin
        cpuGnt  = cpuAhead;
        xferGnt = !cpuAhead;
      end
      default: ;
    endcase
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cpuGnt, xferGnt})) else $error("two grants"); // R8

  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuReq && !xferReq) |-> (!cpuGnt && !xferGnt)) else $error("grant without request"); // R8

  AST_DISABLED_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ.ctlEn && xferReq) |-> xferGnt) else $error("transfer lost while control off"); // R6

  AST_EQUAL_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && xferReq && cfgQ.cpuLvl == cfgQ.xferLvl) |-> xferGnt) else $error("tie not to transfer"); // R7

endmodule

// File: rtl/cpu_xfer_arbiter.sv
module cpu_xfer_arbiter
  import cpu_xfer_arbiter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [LVL_W-1:0] maskLvl,
  input  logic             cpuReq,
  input  logic             xferReq,
  output logic             cpuGnt,
  output logic             xferGnt
);

  strobe_t strobe;
  cfg_t    cfgQ;

  arb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .trackEn (cfgQ.trackEn),
    .strobe  (strobe)
  );

  arb_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .maskLvl (maskLvl),
    .cfgQ    (cfgQ)
  );

  arb_grant u_grant (
    .clk     (clk),
    .rstN    (rstN),
    .cfgQ    (cfgQ),
    .cpuReq  (cpuReq),
    .xferReq (xferReq),
    .cpuGnt  (cpuGnt),
    .xferGnt (xferGnt)
  );

  assign rdData = cfgQ;

endmodule

// File: tb/cpu_xfer_arbiter_tb.sv
module cpu_xfer_arbiter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] maskLvl = '0;
  logic       cpuReq = 1'b0;
  logic       xferReq = 1'b0;
  logic [7:0] rdData;
  logic       cpuGnt, xferGnt;

  int checks = 0;
  int fails = 0;
  logic [7:0] mdl = '0;
  logic       driverDone = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       cg;
    logic       xg;
  } exp_t;
  exp_t sbQ[$];

  always #4 clk = ~clk;

  cpu_xfer_arbiter u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .maskLvl(maskLvl), .cpuReq(cpuReq), .xferReq(xferReq),
    .cpuGnt(cpuGnt), .xferGnt(xferGnt)
  );

  // Expected grants from the requirement text (R6, R7, R8)
  function automatic logic [1:0] expGnt(input logic [7:0] r, input logic cr, input logic xr);
    if (cr && xr) return (r[7] && (r[2:0] > r[6:4])) ? 2'b10 : 2'b01;
    return {cr, xr};
  endfunction

  task automatic compare(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual rd=%h cg=%b xg=%b expected rd=%h cg=%b xg=%b",
               tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
    end
  endtask

  // Driver: drives one cycle of stimulus and pushes its expected outcome
  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] m,
                      input logic cr, input logic xr, input string tag);
    exp_t e;
    logic [7:0] nxt;
    @(negedge clk);
    wrEn = w; wrData = d; maskLvl = m; cpuReq = cr; xferReq = xr;
    nxt = mdl;
    if (w) nxt[7:3] = d[7:3];
    if (mdl[3]) nxt[2:0] = m;
    else if (w) nxt[2:0] = d[2:0];
    mdl = nxt;
    e.tag = tag; e.rd = nxt;
    {e.cg, e.xg} = expGnt(nxt, cr, xr);
    sbQ.push_back(e);
  endtask

  // Monitor: pops one expectation per edge, samples 2 ns after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        e = sbQ.pop_front();
        compare(e.tag, {rdData, cpuGnt, xferGnt}, {e.rd, e.cg, e.xg});
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 in reset", {rdData, cpuGnt, xferGnt}, 10'b0);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset", {rdData, cpuGnt, xferGnt}, 10'b0);

    step(1, 8'hA5, 3'd7, 1, 1, "R2 write, R7 cpu above");
    step(0, 8'h00, 3'd1, 1, 1, "R5 hold with mask change");
    step(1, 8'hD3, 3'd0, 1, 1, "R7 cpu below");
    step(1, 8'hD5, 3'd2, 1, 1, "R7 equal levels");
    step(1, 8'h57, 3'd0, 1, 1, "R6 control off");
    step(0, 8'h00, 3'd0, 1, 0, "R8 sole cpu");
    step(0, 8'h00, 3'd0, 0, 0, "R8 no request");
    step(0, 8'h00, 3'd0, 0, 1, "R8 sole transfer");
    step(1, 8'h88, 3'd6, 1, 1, "R2 enable tracking");
    step(0, 8'h00, 3'd2, 1, 1, "R3 tracked load");
    step(0, 8'h00, 3'd4, 1, 1, "R3 tracked reload");
    step(1, 8'hFE, 3'd1, 1, 1, "R4 write while tracking");
    step(1, 8'h90, 3'd3, 1, 1, "R4 clearing write");
    step(0, 8'h00, 3'd6, 1, 1, "R5 hold after tracking off");
    step(0, 8'h00, 3'd6, 0, 1, "R9 request change");
    step(0, 8'h00, 3'd6, 1, 0, "R9 request change");
    step(0, 8'h00, 3'd6, 1, 1, "R9 request change");

    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], lfsr[15:8], lfsr[4:2], lfsr[6], lfsr[7], "R3 R4 R7 mixed");
    end

    repeat (3) @(negedge clk);
    driverDone = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule